// File: doc/BRIEF.md
# Auto-Restart Protection Supervisor

This block is the protection state machine of an offline switching power controller. It takes digital comparator flags for the supply start and stop thresholds, two feedback levels, a short on-time indication, supply overvoltage, two temperature thresholds and a current-sense overcurrent flag. From them it decides whether the power switch may run, whether the high-voltage startup source must charge the supply, and which fault, if any, stopped the converter.

Every fault ends in the same auto-restart loop. Switching stops at once, and the block waits with both outputs off until the supply falls under its stop level. It then charges the supply again and resumes switching when the supply reaches the start level. A thermal trip also holds off the restart until the die has cooled past the lower temperature threshold. Overload and output-short faults pass through cycle-count filters, so a short excursion is ignored.

Top module: `prot_supervisor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, switching is disabled, the startup source is enabled and the fault code is 0.
- R2: In the charging state, with the start-level flag high and no thermal hold, the next clock edge enables switching and disables the startup source.
- R3: While running, if the above-stop flag goes low and no fault is present, the next edge returns to charging (switching off, startup source on) and leaves the fault code unchanged.
- R4: While running, if the feedback-above-delay flag is high on OLP_DELAY consecutive sampled edges, the last of those edges stops switching with fault code 1. A single low sample restarts the count.
- R5: While running, if the feedback-above-short flag and the short-on-time flag are both high on OSP_HOLD consecutive edges, switching stops with fault code 2. Either flag alone never trips.
- R6: While running, a high supply-overvoltage flag stops switching on the same edge, with fault code 3.
- R7: The overcurrent flag trips (fault code 5) only when the gate-on input is high on the same edge. Without the gate-on input it has no effect.
- R8: An over-temperature flag while running stops switching with fault code 4 and sets a thermal hold. Restart from charging is blocked until the cool flag has been sampled high. The hold clears on that edge, and switching resumes on the next edge.
- R9: After a fault, both outputs are low until the above-stop flag is sampled low, even with the start flag high. The next edge enters charging.
- R10: The fault code keeps the first fault until the next restart, which clears it to 0. When faults arrive on the same edge, the priority is overcurrent (5), then overvoltage (3), then thermal (4), then short (2), then overload (1).
- R11: Fault flags are ignored outside the running state. The filter counters stay cleared there, and the code stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vccAboveStart | input | 1 | Supply at or above the start level |
| vccAboveStop | input | 1 | Supply above the undervoltage stop level |
| fbAboveDelay | input | 1 | Feedback above the overload-delay threshold |
| fbAboveShort | input | 1 | Feedback above the output-short threshold |
| onTimeShort | input | 1 | Last on-time shorter than the short-detect limit |
| vccOverVolt | input | 1 | Supply above the overvoltage level |
| tempHot | input | 1 | Die temperature above the trip point |
| tempCool | input | 1 | Die temperature below the release point |
| gateOn | input | 1 | Power switch gate currently driven on |
| senseOverLimit | input | 1 | Current sense above the abnormal-overcurrent level |
| swEn | output | 1 | Switching allowed |
| startupEn | output | 1 | High-voltage startup source enabled |
| faultCode | output | 3 | Cause of the first fault since the last restart |

## Verification
The hardest state to reach is a thermal hold that outlives a full supply collapse. The stimulus trips the over-temperature flag while running, cycles the supply flags down and back up with the cool flag still low, and confirms that charging persists. It then raises the cool flag and checks the two-edge resume. The filter boundaries are reached by holding each qualifying flag one sample short of its limit, breaking it for one sample, and then holding it exactly to the limit. Simultaneous faults and faults raised during charging or fault wait check the priority order and the first-fault hold.

// File: rtl/prot_supervisor_pkg.sv
package prot_supervisor_pkg;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_WAIT   = 2'd2
  } supState_t;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_OVLOAD  = 3'd1,
    CAUSE_SHORT   = 3'd2,
    CAUSE_OVOLT   = 3'd3,
    CAUSE_THERMAL = 3'd4,
    CAUSE_OCUR    = 3'd5
  } faultCause_t;

  typedef struct packed {
    logic monitorEn;
    logic latchCode;
    logic clearCode;
  } ctrlStrobe_t;

endpackage

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic cond,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = cond && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (!cond)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  // R4
  count_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cond |=> (cnt == '0));

endmodule

// File: rtl/prot_datapath.sv
module prot_datapath
  import prot_supervisor_pkg::*;
#(
  parameter int OLP_DELAY = 40,
  parameter int OSP_HOLD  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        fbAboveDelay,
  input  logic        fbAboveShort,
  input  logic        onTimeShort,
  input  logic        vccOverVolt,
  input  logic        tempHot,
  input  logic        tempCool,
  input  logic        gateOn,
  input  logic        senseOverLimit,
  output logic        faultHit,
  output logic        thermalBlock,
  output logic [2:0]  faultCode
);

  logic olpExpired, ospExpired;
  logic olpCond, ospCond;
  faultCause_t causeNow;
  logic thermalHold;

  assign olpCond = strobe.monitorEn && fbAboveDelay;
  assign ospCond = strobe.monitorEn && fbAboveShort && onTimeShort;

  qual_timer #(.LIMIT(OLP_DELAY)) olpTimer_i (
    .clk(clk), .rstN(rstN), .cond(olpCond), .expired(olpExpired));

  qual_timer #(.LIMIT(OSP_HOLD)) ospTimer_i (
    .clk(clk), .rstN(rstN), .cond(ospCond), .expired(ospExpired));

  always_comb begin
    causeNow = CAUSE_NONE;
    if (strobe.monitorEn) begin
      if (gateOn && senseOverLimit) causeNow = CAUSE_OCUR;
      else if (vccOverVolt)         causeNow = CAUSE_OVOLT;
      else if (tempHot)             causeNow = CAUSE_THERMAL;
      else if (ospExpired)          causeNow = CAUSE_SHORT;
      else if (olpExpired)          causeNow = CAUSE_OVLOAD;
    end
  end

  assign faultHit     = (causeNow != CAUSE_NONE);
  assign thermalBlock = thermalHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             thermalHold <= 1'b0;
    else if (strobe.monitorEn && tempHot)  thermalHold <= 1'b1;
    else if (tempCool)                     thermalHold <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 faultCode <= CAUSE_NONE;
    else if (strobe.latchCode) faultCode <= causeNow;
    else if (strobe.clearCode) faultCode <= CAUSE_NONE;
  end

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 3'd0 && !strobe.clearCode) |=> $stable(faultCode));

  // R7
  ocur_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCode && !gateOn) |=> (faultCode != 3'd5));

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.monitorEn && !strobe.clearCode) |=> $stable(faultCode));

endmodule

// File: rtl/prot_control.sv
module prot_control
  import prot_supervisor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vccAboveStart,
  input  logic        vccAboveStop,
  input  logic        faultHit,
  input  logic        thermalBlock,
  output ctrlStrobe_t strobe,
  output logic        swEn,
  output logic        startupEn
);

  supState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_CHARGE: begin
        if (vccAboveStart && !thermalBlock) begin
          stateNext       = ST_RUN;
          strobe.clearCode = 1'b1;
        end
      end
      ST_RUN: begin
        strobe.monitorEn = 1'b1;
        if (faultHit) begin
          stateNext        = ST_WAIT;
          strobe.latchCode = 1'b1;
        end else if (!vccAboveStop) begin
          stateNext = ST_CHARGE;
        end
      end
      ST_WAIT: begin
        if (!vccAboveStop) stateNext = ST_CHARGE;
      end
      default: stateNext = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CHARGE;
    else       state <= stateNext;
  end

  assign swEn      = (state == ST_RUN);
  assign startupEn = (state == ST_CHARGE);

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startupEn && vccAboveStart && !thermalBlock) |=> swEn);

  // R3
  uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swEn && !faultHit && !vccAboveStop) |=> startupEn);

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && vccAboveStop) |=> (!swEn && !startupEn));

  // R9
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swEn && faultHit) |=> (!swEn && !startupEn));

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_supervisor_pkg::*;
#(
  parameter int OLP_DELAY = 40,
  parameter int OSP_HOLD  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccAboveStart,
  input  logic       vccAboveStop,
  input  logic       fbAboveDelay,
  input  logic       fbAboveShort,
  input  logic       onTimeShort,
  input  logic       vccOverVolt,
  input  logic       tempHot,
  input  logic       tempCool,
  input  logic       gateOn,
  input  logic       senseOverLimit,
  output logic       swEn,
  output logic       startupEn,
  output logic [2:0] faultCode
);

  ctrlStrobe_t strobe;
  logic faultHit, thermalBlock;

  prot_control control_i (
    .clk(clk), .rstN(rstN),
    .vccAboveStart(vccAboveStart), .vccAboveStop(vccAboveStop),
    .faultHit(faultHit), .thermalBlock(thermalBlock),
    .strobe(strobe), .swEn(swEn), .startupEn(startupEn));

  prot_datapath #(.OLP_DELAY(OLP_DELAY), .OSP_HOLD(OSP_HOLD)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fbAboveDelay(fbAboveDelay), .fbAboveShort(fbAboveShort),
    .onTimeShort(onTimeShort), .vccOverVolt(vccOverVolt),
    .tempHot(tempHot), .tempCool(tempCool),
    .gateOn(gateOn), .senseOverLimit(senseOverLimit),
    .faultHit(faultHit), .thermalBlock(thermalBlock),
    .faultCode(faultCode));

endmodule

// File: tb/prot_supervisor_tb.sv
module prot_supervisor_tb_top;

  localparam int OLPD = 12;
  localparam int OSPH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccAboveStart = 0, vccAboveStop = 0, fbAboveDelay = 0, fbAboveShort = 0;
  logic onTimeShort = 0, vccOverVolt = 0, tempHot = 0, tempCool = 0;
  logic gateOn = 0, senseOverLimit = 0;
  logic swEn, startupEn;
  logic [2:0] faultCode;

  always #10 clk = ~clk;

  prot_supervisor #(.OLP_DELAY(OLPD), .OSP_HOLD(OSPH)) dut_i (
    .clk(clk), .rstN(rstN),
    .vccAboveStart(vccAboveStart), .vccAboveStop(vccAboveStop),
    .fbAboveDelay(fbAboveDelay), .fbAboveShort(fbAboveShort),
    .onTimeShort(onTimeShort), .vccOverVolt(vccOverVolt),
    .tempHot(tempHot), .tempCool(tempCool),
    .gateOn(gateOn), .senseOverLimit(senseOverLimit),
    .swEn(swEn), .startupEn(startupEn), .faultCode(faultCode));

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference: 0 charging, 1 running, 2 fault wait
  int mState = 0;
  int mOlp = 0;
  int mOsp = 0;
  int mCode = 0;
  bit mHold = 0;

  always @(posedge clk) begin
    int ns, nc, nOlp, nOsp, cause;
    bit nh, run;
    if (!rstN) begin
      mState = 0; mOlp = 0; mOsp = 0; mCode = 0; mHold = 0;
    end else begin
      run = (mState == 1);
      ns = mState; nc = mCode; nh = mHold; cause = 0;
      nOlp = (run && fbAboveDelay) ? mOlp + 1 : 0;
      nOsp = (run && fbAboveShort && onTimeShort) ? mOsp + 1 : 0;
      if (run) begin
        if (gateOn && senseOverLimit) cause = 5;
        else if (vccOverVolt)         cause = 3;
        else if (tempHot)             cause = 4;
        else if (nOsp >= OSPH)        cause = 2;
        else if (nOlp >= OLPD)        cause = 1;
      end
      case (mState)
        0: if (vccAboveStart && !mHold) begin ns = 1; nc = 0; end
        1: if (cause != 0) begin ns = 2; nc = cause; end
           else if (!vccAboveStop) ns = 0;
        default: if (!vccAboveStop) ns = 0;
      endcase
      if (run && tempHot) nh = 1;
      else if (tempCool)  nh = 0;
      mState = ns; mCode = nc; mHold = nh;
      mOlp = (nOlp > OLPD) ? OLPD : nOlp;
      mOsp = (nOsp > OSPH) ? OSPH : nOsp;
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (swEn !== (mState == 1) || startupEn !== (mState == 0) || faultCode !== 3'(mCode)) begin
      misses++;
      $display("FAIL %s: sw=%0b st=%0b code=%0d expected sw=%0b st=%0b code=%0d",
               curReq, swEn, startupEn, faultCode, mState == 1, mState == 0, mCode);
    end
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(string req, logic sw, logic st, logic [2:0] code);
    vectors++;
    if (swEn !== sw || startupEn !== st || faultCode !== code) begin
      misses++;
      $display("FAIL %s: sw=%0b st=%0b code=%0d expected sw=%0b st=%0b code=%0d",
               req, swEn, startupEn, faultCode, sw, st, code);
    end
  endtask

  task automatic restart();
    vccAboveStop = 0; vccAboveStart = 0; step(1);
    vccAboveStop = 1; vccAboveStart = 1; step(1);
  endtask

  initial begin
    step(3);
    curReq = "R1"; expectOut("R1", 0, 1, 0);
    rstN = 1; step(1);
    expectOut("R1", 0, 1, 0);

    curReq = "R2";
    vccAboveStop = 1; vccAboveStart = 1; step(1);
    expectOut("R2", 1, 0, 0);

    curReq = "R3";
    vccAboveStop = 0; vccAboveStart = 0; step(1);
    expectOut("R3", 0, 1, 0);
    vccAboveStop = 1; vccAboveStart = 1; step(1);
    expectOut("R2", 1, 0, 0);

    curReq = "R4";
    fbAboveDelay = 1; step(OLPD - 1);
    expectOut("R4", 1, 0, 0);
    fbAboveDelay = 0; step(1);
    fbAboveDelay = 1; step(OLPD - 1);
    expectOut("R4", 1, 0, 0);
    step(1);
    expectOut("R4", 0, 0, 1);
    fbAboveDelay = 0;

    curReq = "R9";
    step(3);
    expectOut("R9", 0, 0, 1);
    vccAboveStop = 0; vccAboveStart = 0; step(1);
    expectOut("R9", 0, 1, 1);
    vccAboveStop = 1; vccAboveStart = 1; step(1);
    expectOut("R10", 1, 0, 0);

    curReq = "R5";
    fbAboveShort = 1; step(OSPH + 3);
    expectOut("R5", 1, 0, 0);
    fbAboveShort = 0; onTimeShort = 1; step(OSPH + 3);
    expectOut("R5", 1, 0, 0);
    fbAboveShort = 1; step(OSPH - 1);
    expectOut("R5", 1, 0, 0);
    step(1);
    expectOut("R5", 0, 0, 2);
    fbAboveShort = 0; onTimeShort = 0;
    restart();

    curReq = "R6";
    vccOverVolt = 1; step(1);
    expectOut("R6", 0, 0, 3);
    vccOverVolt = 0;
    restart();

    curReq = "R7";
    senseOverLimit = 1; step(4);
    expectOut("R7", 1, 0, 0);
    gateOn = 1; step(1);
    expectOut("R7", 0, 0, 5);
    gateOn = 0; senseOverLimit = 0;
    restart();

    curReq = "R8";
    tempHot = 1; step(1);
    expectOut("R8", 0, 0, 4);
    tempHot = 0;
    vccAboveStop = 0; vccAboveStart = 0; step(1);
    vccAboveStop = 1; vccAboveStart = 1; step(4);
    expectOut("R8", 0, 1, 4);
    tempCool = 1; step(1);
    expectOut("R8", 0, 1, 4);
    step(1);
    expectOut("R8", 1, 0, 0);
    tempCool = 0;

    curReq = "R10";
    vccOverVolt = 1; gateOn = 1; senseOverLimit = 1; tempHot = 1; fbAboveDelay = 1;
    step(1);
    expectOut("R10", 0, 0, 5);
    gateOn = 0; senseOverLimit = 0; fbAboveDelay = 0;
    step(3);
    expectOut("R10", 0, 0, 5);
    vccOverVolt = 0; tempHot = 0; tempCool = 1;
    restart();
    step(1);
    tempCool = 0;
    expectOut("R10", 1, 0, 0);
    vccOverVolt = 1; tempHot = 1; step(1);
    expectOut("R10", 0, 0, 3);
    vccOverVolt = 0; tempHot = 0; tempCool = 1;
    restart();
    step(1);
    tempCool = 0;
    expectOut("R10", 1, 0, 0);

    curReq = "R11";
    vccAboveStop = 0; vccAboveStart = 0; step(1);
    vccOverVolt = 1; gateOn = 1; senseOverLimit = 1; tempHot = 1;
    fbAboveDelay = 1; fbAboveShort = 1; onTimeShort = 1;
    step(OLPD + 2);
    expectOut("R11", 0, 1, 0);
    vccOverVolt = 0; gateOn = 0; senseOverLimit = 0; tempHot = 0;
    fbAboveShort = 0; onTimeShort = 0; fbAboveDelay = 0;
    vccAboveStop = 1; vccAboveStart = 1; step(1);
    expectOut("R11", 1, 0, 0);
    fbAboveDelay = 1; step(1);
    expectOut("R11", 1, 0, 0);
    fbAboveDelay = 0; step(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule